// File: doc/BRIEF.md
# Beamformer Control and Status Register Slave

This block is the AXI4-Lite register front end of a multi-antenna beamformer. It holds a small set of configuration registers whose values drive the processing logic directly, it captures a latency measurement and error events reported by that logic, and it stores a two-dimensional per-beam, per-antenna delay array. The delay array can be written from the bus and read by the processing logic through its own read port.

Three address windows are not stored inside the block. A write that lands in one of them leaves as a one-cycle strobe, a word index and a data word, ready to drive a memory that sits outside. These windows have no read path. A bus read to one of them completes at once with an error response rather than hanging the bus. Error events are sticky and are cleared by a bus write. When a clear and a new error event arrive in the same cycle, the clear wins.

Top module: `bf_csr_slave`

## Requirements
- R1: After reset, a read of offset 0x000 returns the build word 0x20210522 with an OKAY response, tp_sel_o is 0, err_flags_o is 0, no table strobe is active, and neither bvalid nor rvalid is asserted.
- R2: Offsets 0x004 (control, bits 3:0), 0x008 (load time, 32 bits), 0x00C (channel count, bits 8:3 only) and 0x014 (test-point select, bits 7:0) read back only their writable bits, with the other bits zero. ctrl_o, load_time_o, chan_cnt_o (the value of bits 8:3) and tp_sel_o follow the stored values one cycle after the write handshake.
- R3: Offset 0x018 is loaded by a lat_we_i pulse. It reads as count in bits 15:0, start in bit 16 and stop in bit 17. A bus write there gets OKAY and changes nothing.
- R4: A one-cycle pulse on err_pulse_i[k] sets err_flags_o[k] on the next cycle, and the flag stays set. Offset 0x01C reads the flags in bits 2:0.
- R5: A write to 0x01C with bit 3 set clears all flags one cycle after the handshake, even when a new pulse arrives in the handshake cycle. err_clear_o is high for exactly that one cycle. A write with bit 3 clear leaves the flags unchanged.
- R6: A write at 0x080–0x0BF, 0x0C0–0x0FF or 0x100–0x1FF gives, one cycle after the handshake, a one-cycle strobe on roff_we_o, bidx_we_o or rsel_we_o respectively. The strobe carries the word index (address bits from bit 2 upward within the window) and the data on tbl_wdata_o, and the write gets OKAY. At most one strobe is high at a time.
- R7: A read anywhere in the three table windows returns zero data with SLVERR (2'b10).
- R8: The delay word for outer index d (0–7) and inner index b (0–7) is written at 0x200 + d·0x20 + b·4. It appears on dly_rdata_o one cycle after dly_raddr_i = d·8+b is presented. A bus read of a delay word returns zero with OKAY.
- R9: A read or write to an unmapped offset (for example 0x010, 0x040 or 0x300 and above) returns SLVERR, a read returns zero, and a write changes no register output.
- R10: Each write handshake yields exactly one write response. bvalid and rvalid, once raised, hold with stable response and data until bready or rready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (00 OKAY, 10 SLVERR) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ctrl_o | output | 4 | Control bits (0 reset, 1 immediate load, 2 deferred load, 3 spare) |
| load_time_o | output | 32 | Deferred load time in frames |
| chan_cnt_o | output | 6 | Channel count field |
| tp_sel_o | output | 8 | Test-point select |
| lat_we_i | input | 1 | Latency capture enable |
| lat_count_i | input | 16 | Latency count |
| lat_start_i | input | 1 | Count-started flag |
| lat_stop_i | input | 1 | Count-stopped flag |
| err_pulse_i | input | 3 | Error event pulses (0 empty read, 1 full write, 2 misaligned packet end) |
| err_flags_o | output | 3 | Sticky error flags |
| err_clear_o | output | 1 | One-cycle pulse when the flags are cleared |
| roff_we_o | output | 1 | Region-offset table write strobe |
| roff_idx_o | output | ROFF_IW | Region-offset word index |
| bidx_we_o | output | 1 | Beam-index table write strobe |
| bidx_idx_o | output | BIDX_IW | Beam-index word index |
| rsel_we_o | output | 1 | Region-select table write strobe |
| rsel_idx_o | output | RSEL_IW | Region-select word index |
| tbl_wdata_o | output | 32 | Data word for any table strobe |
| dly_raddr_i | input | DLY_AW | Delay array read index (outer·8+inner) |
| dly_rdata_o | output | 32 | Delay array read data |

## Verification
The collision that matters is a bus write of the error-clear bit whose handshake falls in the same cycle as a new hardware error pulse. The bench watches for the cycle in which the ready output shows that the handshake will happen on the next edge. It raises an error pulse exactly there, and expects every flag to read zero afterwards, with a single clear pulse. A second coincidence, an independent read and write running on the two channels at once, is covered by checking each response on its own channel. Meanwhile a per-cycle model compares strobes, flags and register outputs on every clock.

// File: rtl/bf_csr_pkg.sv
package bf_csr_pkg;

  typedef enum logic [3:0] {
    RG_DATE  = 4'd0,
    RG_CTRL  = 4'd1,
    RG_LTIME = 4'd2,
    RG_NCH   = 4'd3,
    RG_TPS   = 4'd4,
    RG_LAT   = 4'd5,
    RG_ERR   = 4'd6,
    RG_TROFF = 4'd7,
    RG_TBIDX = 4'd8,
    RG_TRSEL = 4'd9,
    RG_DLY   = 4'd10,
    RG_NONE  = 4'd11
  } region_e;

  localparam int unsigned OFS_DATE  = 32'h000;
  localparam int unsigned OFS_CTRL  = 32'h004;
  localparam int unsigned OFS_LTIME = 32'h008;
  localparam int unsigned OFS_NCH   = 32'h00C;
  localparam int unsigned OFS_TPS   = 32'h014;
  localparam int unsigned OFS_LAT   = 32'h018;
  localparam int unsigned OFS_ERR   = 32'h01C;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam int ERR_N     = 3;
  localparam int ERR_CLR_B = 3;

endpackage

// File: rtl/bf_csr_decode.sv
module bf_csr_decode
  import bf_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ROFF_BASE = 12'h080,
  parameter int ROFF_DEPTH = 16,
  parameter logic [ADDR_W-1:0] BIDX_BASE = 12'h0C0,
  parameter int BIDX_DEPTH = 16,
  parameter logic [ADDR_W-1:0] RSEL_BASE = 12'h100,
  parameter int RSEL_DEPTH = 64,
  parameter logic [ADDR_W-1:0] DLY_BASE = 12'h200,
  parameter int DLY_OUTER = 8,
  parameter int DLY_INNER = 8,
  parameter int DLY_STRIDE = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           rg_o
);

  localparam int STRIDE_SH = $clog2(DLY_STRIDE);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(OFS_DATE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LTIME = ADDR_W'(OFS_LTIME);
  localparam logic [ADDR_W-1:0] A_NCH   = ADDR_W'(OFS_NCH);
  localparam logic [ADDR_W-1:0] A_TPS   = ADDR_W'(OFS_TPS);
  localparam logic [ADDR_W-1:0] A_LAT   = ADDR_W'(OFS_LAT);
  localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(OFS_ERR);
  localparam logic [ADDR_W-1:0] ROFF_END = ROFF_BASE + ADDR_W'(4 * ROFF_DEPTH);
  localparam logic [ADDR_W-1:0] BIDX_END = BIDX_BASE + ADDR_W'(4 * BIDX_DEPTH);
  localparam logic [ADDR_W-1:0] RSEL_END = RSEL_BASE + ADDR_W'(4 * RSEL_DEPTH);
  localparam logic [ADDR_W-1:0] DLY_END  = DLY_BASE + ADDR_W'(DLY_OUTER * DLY_STRIDE);

  logic [ADDR_W-1:0] word_a;
  logic              unused_lsb;
  logic              inner_ok;

  assign word_a     = {addr_i[ADDR_W-1:2], 2'b00};
  assign unused_lsb = ^addr_i[1:0];

  generate
    if (DLY_INNER * 4 == DLY_STRIDE) begin : g_dense
      assign inner_ok = 1'b1;
    end else begin : g_sparse
      assign inner_ok = (int'(addr_i[STRIDE_SH-1:2]) < DLY_INNER);
    end
  endgenerate

  always_comb begin
    rg_o = RG_NONE;
    if (word_a == A_DATE)                              rg_o = RG_DATE;
    else if (word_a == A_CTRL)                         rg_o = RG_CTRL;
    else if (word_a == A_LTIME)                        rg_o = RG_LTIME;
    else if (word_a == A_NCH)                          rg_o = RG_NCH;
    else if (word_a == A_TPS)                          rg_o = RG_TPS;
    else if (word_a == A_LAT)                          rg_o = RG_LAT;
    else if (word_a == A_ERR)                          rg_o = RG_ERR;
    else if (word_a >= ROFF_BASE && word_a < ROFF_END) rg_o = RG_TROFF;
    else if (word_a >= BIDX_BASE && word_a < BIDX_END) rg_o = RG_TBIDX;
    else if (word_a >= RSEL_BASE && word_a < RSEL_END) rg_o = RG_TRSEL;
    else if (word_a >= DLY_BASE && word_a < DLY_END && inner_ok) rg_o = RG_DLY;
  end

endmodule

// File: rtl/bf_csr_errflags.sv
module bf_csr_errflags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o,
  output logic         clr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      clr_o   <= 1'b0;
    end else begin
      clr_o <= clr_i;
      if (clr_i) flags_o <= '0;
      else       flags_o <= flags_o | pulse_i;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (pulse_i != '0 && !clr_i) |=> ((flags_o & $past(pulse_i)) == $past(pulse_i))); // R4
  AST_ERR_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (flags_o == '0 && clr_o)); // R5

endmodule

// File: rtl/bf_csr_winport.sv
module bf_csr_winport #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_i,
  input  logic [IW-1:0] idx_i,
  output logic          we_o,
  output logic [IW-1:0] idx_o
);

  always_ff @(posedge clk) begin
    if (rst) we_o <= 1'b0;
    else     we_o <= hit_i;
  end

  always_ff @(posedge clk) begin
    if (hit_i) idx_o <= idx_i;
  end

  AST_WIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    we_o && !hit_i |=> !we_o); // R6

endmodule

// File: rtl/bf_csr_delay_bank.sv
module bf_csr_delay_bank #(
  parameter int DEPTH = 64,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/bf_csr_slave.sv
module bf_csr_slave
  import bf_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [31:0] BUILD_DATE = 32'h20210522,
  parameter logic [ADDR_W-1:0] ROFF_BASE = 12'h080,
  parameter int ROFF_DEPTH = 16,
  parameter logic [ADDR_W-1:0] BIDX_BASE = 12'h0C0,
  parameter int BIDX_DEPTH = 16,
  parameter logic [ADDR_W-1:0] RSEL_BASE = 12'h100,
  parameter int RSEL_DEPTH = 64,
  parameter logic [ADDR_W-1:0] DLY_BASE = 12'h200,
  parameter int DLY_OUTER = 8,
  parameter int DLY_INNER = 8,
  parameter int DLY_STRIDE = 32,
  localparam int ROFF_IW = $clog2(ROFF_DEPTH),
  localparam int BIDX_IW = $clog2(BIDX_DEPTH),
  localparam int RSEL_IW = $clog2(RSEL_DEPTH),
  localparam int DLY_OW = $clog2(DLY_OUTER),
  localparam int DLY_IW = $clog2(DLY_INNER),
  localparam int DLY_AW = DLY_OW + DLY_IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [31:0]        s_wdata,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [ADDR_W-1:0]  s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [3:0]         ctrl_o,
  output logic [31:0]        load_time_o,
  output logic [5:0]         chan_cnt_o,
  output logic [7:0]         tp_sel_o,
  input  logic               lat_we_i,
  input  logic [15:0]        lat_count_i,
  input  logic               lat_start_i,
  input  logic               lat_stop_i,
  input  logic [2:0]         err_pulse_i,
  output logic [2:0]         err_flags_o,
  output logic               err_clear_o,
  output logic               roff_we_o,
  output logic [ROFF_IW-1:0] roff_idx_o,
  output logic               bidx_we_o,
  output logic [BIDX_IW-1:0] bidx_idx_o,
  output logic               rsel_we_o,
  output logic [RSEL_IW-1:0] rsel_idx_o,
  output logic [31:0]        tbl_wdata_o,
  input  logic [DLY_AW-1:0]  dly_raddr_i,
  output logic [31:0]        dly_rdata_o
);

  localparam int STRIDE_SH = $clog2(DLY_STRIDE);

  region_e wr_rg, rd_rg;
  logic    aw_rdy_q, ar_rdy_q;
  logic    wr_fire, rd_fire;
  logic    err_clr;
  logic [15:0] lat_cnt_q;
  logic        lat_start_q, lat_stop_q;
  logic [DLY_AW-1:0] dly_waddr;
  logic [31:0] rd_word;
  logic [1:0]  rd_resp;

  // two identical decoders, one per channel
  bf_csr_decode #(
    .ADDR_W(ADDR_W), .ROFF_BASE(ROFF_BASE), .ROFF_DEPTH(ROFF_DEPTH),
    .BIDX_BASE(BIDX_BASE), .BIDX_DEPTH(BIDX_DEPTH),
    .RSEL_BASE(RSEL_BASE), .RSEL_DEPTH(RSEL_DEPTH),
    .DLY_BASE(DLY_BASE), .DLY_OUTER(DLY_OUTER), .DLY_INNER(DLY_INNER),
    .DLY_STRIDE(DLY_STRIDE)
  ) u_wr_dec (.addr_i(s_awaddr), .rg_o(wr_rg));

  bf_csr_decode #(
    .ADDR_W(ADDR_W), .ROFF_BASE(ROFF_BASE), .ROFF_DEPTH(ROFF_DEPTH),
    .BIDX_BASE(BIDX_BASE), .BIDX_DEPTH(BIDX_DEPTH),
    .RSEL_BASE(RSEL_BASE), .RSEL_DEPTH(RSEL_DEPTH),
    .DLY_BASE(DLY_BASE), .DLY_OUTER(DLY_OUTER), .DLY_INNER(DLY_INNER),
    .DLY_STRIDE(DLY_STRIDE)
  ) u_rd_dec (.addr_i(s_araddr), .rg_o(rd_rg));

  // ---------------- write channel ----------------
  assign s_awready = aw_rdy_q;
  assign s_wready  = aw_rdy_q;
  assign wr_fire   = aw_rdy_q && s_awvalid && s_wvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_rdy_q <= 1'b0;
      s_bvalid <= 1'b0;
      s_bresp  <= RESP_OKAY;
    end else begin
      aw_rdy_q <= !aw_rdy_q && s_awvalid && s_wvalid && !s_bvalid;
      if (wr_fire) begin
        s_bvalid <= 1'b1;
        s_bresp  <= (wr_rg == RG_NONE) ? RESP_SLVERR : RESP_OKAY;
      end else if (s_bready) begin
        s_bvalid <= 1'b0;
      end
    end
  end

  // configuration registers without a defined reset value
  always_ff @(posedge clk) begin
    if (wr_fire && wr_rg == RG_CTRL)  ctrl_o      <= s_wdata[3:0];
    if (wr_fire && wr_rg == RG_LTIME) load_time_o <= s_wdata;
    if (wr_fire && wr_rg == RG_NCH)   chan_cnt_o  <= s_wdata[8:3];
  end

  always_ff @(posedge clk) begin
    if (rst)                              tp_sel_o <= '0;
    else if (wr_fire && wr_rg == RG_TPS)  tp_sel_o <= s_wdata[7:0];
  end

  // hardware-written latency word
  always_ff @(posedge clk) begin
    if (lat_we_i) begin
      lat_cnt_q   <= lat_count_i;
      lat_start_q <= lat_start_i;
      lat_stop_q  <= lat_stop_i;
    end
  end

  // sticky error flags, bus clear has priority
  assign err_clr = wr_fire && (wr_rg == RG_ERR) && s_wdata[ERR_CLR_B];

  bf_csr_errflags #(.N(ERR_N)) u_err (
    .clk(clk), .rst(rst), .pulse_i(err_pulse_i), .clr_i(err_clr),
    .flags_o(err_flags_o), .clr_o(err_clear_o)
  );

  // table windows: strobe, index, shared data word
  bf_csr_winport #(.IW(ROFF_IW)) u_roff (
    .clk(clk), .rst(rst), .hit_i(wr_fire && wr_rg == RG_TROFF),
    .idx_i(s_awaddr[ROFF_IW+1:2]), .we_o(roff_we_o), .idx_o(roff_idx_o)
  );
  bf_csr_winport #(.IW(BIDX_IW)) u_bidx (
    .clk(clk), .rst(rst), .hit_i(wr_fire && wr_rg == RG_TBIDX),
    .idx_i(s_awaddr[BIDX_IW+1:2]), .we_o(bidx_we_o), .idx_o(bidx_idx_o)
  );
  bf_csr_winport #(.IW(RSEL_IW)) u_rsel (
    .clk(clk), .rst(rst), .hit_i(wr_fire && wr_rg == RG_TRSEL),
    .idx_i(s_awaddr[RSEL_IW+1:2]), .we_o(rsel_we_o), .idx_o(rsel_idx_o)
  );

  always_ff @(posedge clk) begin
    if (wr_fire && (wr_rg == RG_TROFF || wr_rg == RG_TBIDX || wr_rg == RG_TRSEL))
      tbl_wdata_o <= s_wdata;
  end

  // delay array: outer index from the stride bits, inner from the word bits
  assign dly_waddr = {s_awaddr[STRIDE_SH+DLY_OW-1:STRIDE_SH], s_awaddr[DLY_IW+1:2]};

  bf_csr_delay_bank #(.DEPTH(DLY_OUTER * DLY_INNER), .DW(32)) u_dly (
    .clk(clk), .we_i(wr_fire && wr_rg == RG_DLY), .waddr_i(dly_waddr),
    .wdata_i(s_wdata), .raddr_i(dly_raddr_i), .rdata_o(dly_rdata_o)
  );

  // ---------------- read channel ----------------
  assign s_arready = ar_rdy_q;
  assign rd_fire   = ar_rdy_q && s_arvalid;

  always_comb begin
    rd_word = '0;
    rd_resp = RESP_OKAY;
    unique case (rd_rg)
      RG_DATE:  rd_word = BUILD_DATE;
      RG_CTRL:  rd_word = {28'd0, ctrl_o};
      RG_LTIME: rd_word = load_time_o;
      RG_NCH:   rd_word = {23'd0, chan_cnt_o, 3'd0};
      RG_TPS:   rd_word = {24'd0, tp_sel_o};
      RG_LAT:   rd_word = {14'd0, lat_stop_q, lat_start_q, lat_cnt_q};
      RG_ERR:   rd_word = {28'd0, err_clear_o, err_flags_o};
      RG_DLY:   rd_word = '0;
      RG_TROFF, RG_TBIDX, RG_TRSEL, RG_NONE: rd_resp = RESP_SLVERR;
      default:  rd_resp = RESP_SLVERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_rdy_q <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      s_rresp  <= RESP_OKAY;
    end else begin
      ar_rdy_q <= !ar_rdy_q && s_arvalid && !s_rvalid;
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_word;
        s_rresp  <= rd_resp;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R10
  AST_RRESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp))); // R10
  AST_WRITE_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> s_bvalid); // R10
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({roff_we_o, bidx_we_o, rsel_we_o})); // R6
  AST_STROBE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (roff_we_o || bidx_we_o || rsel_we_o) |-> ($past(wr_fire) && s_bvalid && s_bresp == RESP_OKAY)); // R6
  AST_TABLE_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && (rd_rg == RG_TROFF || rd_rg == RG_TBIDX || rd_rg == RG_TRSEL))
      |=> (s_rvalid && s_rresp == RESP_SLVERR && s_rdata == '0)); // R7
  AST_DATE_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_rg == RG_DATE) |=> (s_rdata == BUILD_DATE && s_rresp == RESP_OKAY)); // R1
  AST_DELAY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_rg == RG_DLY) |=> (s_rdata == '0 && s_rresp == RESP_OKAY)); // R8
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_rg == RG_NONE) |=> (s_rdata == '0 && s_rresp == RESP_SLVERR)); // R9

endmodule

// File: tb/bf_csr_slave_bench.sv
`timescale 1ns/1ps
module bf_csr_slave_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [11:0] s_awaddr = '0;
  logic        s_awvalid = 1'b0, s_awready;
  logic [31:0] s_wdata = '0;
  logic        s_wvalid = 1'b0, s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid, s_bready = 1'b0;
  logic [11:0] s_araddr = '0;
  logic        s_arvalid = 1'b0, s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid, s_rready = 1'b0;
  logic [3:0]  ctrl_o;
  logic [31:0] load_time_o;
  logic [5:0]  chan_cnt_o;
  logic [7:0]  tp_sel_o;
  logic        lat_we_i = 1'b0;
  logic [15:0] lat_count_i = '0;
  logic        lat_start_i = 1'b0, lat_stop_i = 1'b0;
  logic [2:0]  err_pulse_i = '0;
  logic [2:0]  err_flags_o;
  logic        err_clear_o;
  logic        roff_we_o, bidx_we_o, rsel_we_o;
  logic [3:0]  roff_idx_o, bidx_idx_o;
  logic [5:0]  rsel_idx_o;
  logic [31:0] tbl_wdata_o;
  logic [5:0]  dly_raddr_i = '0;
  logic [31:0] dly_rdata_o;

  bf_csr_slave u_bf_csr_slave (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .ctrl_o(ctrl_o), .load_time_o(load_time_o), .chan_cnt_o(chan_cnt_o), .tp_sel_o(tp_sel_o),
    .lat_we_i(lat_we_i), .lat_count_i(lat_count_i), .lat_start_i(lat_start_i), .lat_stop_i(lat_stop_i),
    .err_pulse_i(err_pulse_i), .err_flags_o(err_flags_o), .err_clear_o(err_clear_o),
    .roff_we_o(roff_we_o), .roff_idx_o(roff_idx_o), .bidx_we_o(bidx_we_o), .bidx_idx_o(bidx_idx_o),
    .rsel_we_o(rsel_we_o), .rsel_idx_o(rsel_idx_o), .tbl_wdata_o(tbl_wdata_o),
    .dly_raddr_i(dly_raddr_i), .dly_rdata_o(dly_rdata_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // region codes of the bench's own address map
  function automatic int region_of(int unsigned a);
    int unsigned w = a & 32'hFFFF_FFFC;
    if (w == 0)  return 0;
    if (w == 4)  return 1;
    if (w == 8)  return 2;
    if (w == 12) return 3;
    if (w == 20) return 4;
    if (w == 24) return 5;
    if (w == 28) return 6;
    if (w >= 128 && w < 192) return 7;
    if (w >= 192 && w < 256) return 8;
    if (w >= 256 && w < 512) return 9;
    if (w >= 512 && w < 768) return 10;
    return 11;
  endfunction

  // ---------------- cycle-by-cycle reference model ----------------
  bit          pv_rst, pv_fire;
  int unsigned pv_addr;
  logic [31:0] pv_data;
  logic [2:0]  pv_pulse;

  always @(posedge clk) begin
    pv_rst   <= rst;
    pv_fire  <= s_awvalid && s_wvalid && s_awready;
    pv_addr  <= int'(s_awaddr);
    pv_data  <= s_wdata;
    pv_pulse <= err_pulse_i;
  end

  logic [2:0]  m_flags = '0;
  bit          m_clr = 0;
  bit          m_we_r = 0, m_we_b = 0, m_we_s = 0;
  int unsigned m_idx = 0;
  logic [31:0] m_tdata = '0;
  logic [3:0]  m_ctrl;   bit k_ctrl = 0;
  logic [31:0] m_ltime;  bit k_ltime = 0;
  logic [5:0]  m_nch;    bit k_nch = 0;
  logic [7:0]  m_tps = '0;
  bit          model_on = 0;

  always @(negedge clk) begin
    int rg;
    rg = region_of(pv_addr);
    m_we_r = 0; m_we_b = 0; m_we_s = 0; m_clr = 0;
    if (pv_rst) begin
      m_flags = '0;
      m_tps   = '0;
    end else begin
      if (pv_fire && rg == 6 && pv_data[3]) begin
        m_flags = '0;
        m_clr   = 1;
      end else begin
        m_flags = m_flags | pv_pulse;
      end
      if (pv_fire) begin
        case (rg)
          1: begin m_ctrl = pv_data[3:0]; k_ctrl = 1; end
          2: begin m_ltime = pv_data; k_ltime = 1; end
          3: begin m_nch = pv_data[8:3]; k_nch = 1; end
          4: m_tps = pv_data[7:0];
          7: begin m_we_r = 1; m_idx = (pv_addr - 128) >> 2; m_tdata = pv_data; end
          8: begin m_we_b = 1; m_idx = (pv_addr - 192) >> 2; m_tdata = pv_data; end
          9: begin m_we_s = 1; m_idx = (pv_addr - 256) >> 2; m_tdata = pv_data; end
          default: ;
        endcase
      end
    end
    if (model_on) begin
      check("R4/R5 err_flags_o", 32'(err_flags_o), 32'(m_flags));
      check("R5 err_clear_o", 32'(err_clear_o), 32'(m_clr));
      check("R6 strobes", {29'd0, roff_we_o, bidx_we_o, rsel_we_o}, {29'd0, m_we_r, m_we_b, m_we_s});
      if (m_we_r) check("R6 roff_idx_o", 32'(roff_idx_o), m_idx);
      if (m_we_b) check("R6 bidx_idx_o", 32'(bidx_idx_o), m_idx);
      if (m_we_s) check("R6 rsel_idx_o", 32'(rsel_idx_o), m_idx);
      if (m_we_r || m_we_b || m_we_s) check("R6 tbl_wdata_o", tbl_wdata_o, m_tdata);
      check("R2 tp_sel_o", 32'(tp_sel_o), 32'(m_tps));
      if (k_ctrl)  check("R2 ctrl_o", 32'(ctrl_o), 32'(m_ctrl));
      if (k_ltime) check("R2 load_time_o", load_time_o, m_ltime);
      if (k_nch)   check("R2 chan_cnt_o", 32'(chan_cnt_o), 32'(m_nch));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] exp_resp,
                           input string tag, input logic [2:0] pulse_at_fire = 3'b000,
                           input int bhold = 0);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
    do @(negedge clk); while (!s_awready);
    err_pulse_i = pulse_at_fire;
    @(negedge clk);
    err_pulse_i = '0;
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    check({tag, " bvalid"}, 32'(s_bvalid), 32'd1);
    check({tag, " bresp"}, 32'(s_bresp), 32'(exp_resp));
    for (int i = 0; i < bhold; i++) begin
      @(negedge clk);
      check("R10 bvalid held", 32'(s_bvalid), 32'd1);
      check("R10 bresp stable", 32'(s_bresp), 32'(exp_resp));
    end
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    check("R10 single response", 32'(s_bvalid), 32'd0);
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp_d, input logic [1:0] exp_resp,
                          input string tag, input int rhold = 0);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    do @(negedge clk); while (!s_arready);
    @(negedge clk);
    s_arvalid = 1'b0;
    check({tag, " rvalid"}, 32'(s_rvalid), 32'd1);
    check({tag, " rdata"}, s_rdata, exp_d);
    check({tag, " rresp"}, 32'(s_rresp), 32'(exp_resp));
    for (int i = 0; i < rhold; i++) begin
      @(negedge clk);
      check("R10 rvalid held", 32'(s_rvalid), 32'd1);
      check("R10 rdata stable", s_rdata, exp_d);
    end
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    check("R10 rvalid dropped", 32'(s_rvalid), 32'd0);
  endtask

  task automatic pulse_err(input logic [2:0] p);
    @(negedge clk); err_pulse_i = p;
    @(negedge clk); err_pulse_i = '0;
  endtask

  task automatic pulse_lat(input logic [15:0] c, input logic st, input logic sp);
    @(negedge clk);
    lat_we_i = 1'b1; lat_count_i = c; lat_start_i = st; lat_stop_i = sp;
    @(negedge clk);
    lat_we_i = 1'b0;
  endtask

  task automatic dly_port(input logic [5:0] idx, input logic [31:0] exp_d);
    @(negedge clk); dly_raddr_i = idx;
    @(negedge clk);
    check("R8 dly_rdata_o", dly_rdata_o, exp_d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  localparam logic [1:0] OK = 2'b00;
  localparam logic [1:0] SE = 2'b10;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_on = 1;

    // R1 reset state
    check("R1 err_flags_o", 32'(err_flags_o), 32'd0);
    check("R1 tp_sel_o", 32'(tp_sel_o), 32'd0);
    check("R1 bvalid/rvalid", {30'd0, s_bvalid, s_rvalid}, 32'd0);
    bus_read(12'h000, 32'h20210522, OK, "R1 date");

    // R2 writable fields
    bus_write(12'h004, 32'hFFFF_FFFF, OK, "R2 ctrl wr");
    bus_read(12'h004, 32'h0000_000F, OK, "R2 ctrl rd");
    bus_write(12'h004, 32'h0000_0005, OK, "R2 ctrl wr2");
    bus_read(12'h004, 32'h0000_0005, OK, "R2 ctrl rd2");
    bus_write(12'h008, 32'hDEAD_BEEF, OK, "R2 ltime wr");
    bus_read(12'h008, 32'hDEAD_BEEF, OK, "R2 ltime rd");
    bus_write(12'h00C, 32'h0000_FFFF, OK, "R2 nch wr");
    bus_read(12'h00C, 32'h0000_01F8, OK, "R2 nch rd");
    check("R2 chan_cnt_o all", 32'(chan_cnt_o), 32'h3F);
    bus_write(12'h00C, 32'h0000_0087, OK, "R2 nch wr2");
    bus_read(12'h00C, 32'h0000_0080, OK, "R2 nch rd2");
    bus_write(12'h014, 32'h0000_01A5, OK, "R2 tps wr");
    bus_read(12'h014, 32'h0000_00A5, OK, "R2 tps rd");

    // R3 latency word
    pulse_lat(16'h1234, 1'b1, 1'b0);
    bus_read(12'h018, 32'h0001_1234, OK, "R3 lat rd");
    bus_write(12'h018, 32'h0000_0000, OK, "R3 lat wr ignored");
    bus_read(12'h018, 32'h0001_1234, OK, "R3 lat unchanged");
    pulse_lat(16'hFFFF, 1'b0, 1'b1);
    bus_read(12'h018, 32'h0002_FFFF, OK, "R3 lat rd2");

    // R4 sticky flags
    pulse_err(3'b010);
    repeat (3) @(negedge clk);
    bus_read(12'h01C, 32'h0000_0002, OK, "R4 err rd");
    pulse_err(3'b101);
    bus_read(12'h01C, 32'h0000_0007, OK, "R4 err rd all");

    // R5 clear semantics
    bus_write(12'h01C, 32'h0000_0007, OK, "R5 no-clear wr");
    bus_read(12'h01C, 32'h0000_0007, OK, "R5 flags kept");
    bus_write(12'h01C, 32'h0000_0008, OK, "R5 clear with collision", 3'b001);
    check("R5 flags after collision", 32'(err_flags_o), 32'd0);
    bus_read(12'h01C, 32'h0000_0000, OK, "R5 err rd cleared");
    pulse_err(3'b100);
    bus_read(12'h01C, 32'h0000_0004, OK, "R5 set after clear");
    bus_write(12'h01C, 32'h0000_0008, OK, "R5 plain clear");
    bus_read(12'h01C, 32'h0000_0000, OK, "R5 err rd cleared2");

    // R6 table windows
    bus_write(12'h08C, 32'hA000_0003, OK, "R6 roff 3");
    bus_write(12'h0BC, 32'hA000_000F, OK, "R6 roff 15");
    bus_write(12'h0C0, 32'hB000_0000, OK, "R6 bidx 0");
    bus_write(12'h0E4, 32'hB000_0009, OK, "R6 bidx 9");
    bus_write(12'h100, 32'hC000_0000, OK, "R6 rsel 0");
    bus_write(12'h1FC, 32'hC000_003F, OK, "R6 rsel 63");

    // R7 table reads fail
    bus_read(12'h084, 32'h0, SE, "R7 roff rd");
    bus_read(12'h0C8, 32'h0, SE, "R7 bidx rd");
    bus_read(12'h1F0, 32'h0, SE, "R7 rsel rd");

    // R8 delay array
    bus_write(12'h254, 32'h1111_2505, OK, "R8 dly d2 b5");
    bus_write(12'h2FC, 32'h7777_7777, OK, "R8 dly d7 b7");
    bus_write(12'h200, 32'h0000_00AA, OK, "R8 dly d0 b0");
    bus_read(12'h254, 32'h0, OK, "R8 dly bus rd");
    dly_port(6'd21, 32'h1111_2505);
    dly_port(6'd63, 32'h7777_7777);
    dly_port(6'd0,  32'h0000_00AA);

    // R9 unmapped
    bus_read(12'h010, 32'h0, SE, "R9 rd 0x010");
    bus_read(12'h040, 32'h0, SE, "R9 rd 0x040");
    bus_read(12'h300, 32'h0, SE, "R9 rd 0x300");
    bus_write(12'h010, 32'hFFFF_FFFF, SE, "R9 wr 0x010");
    bus_write(12'h304, 32'hFFFF_FFFF, SE, "R9 wr 0x304");
    bus_read(12'h004, 32'h0000_0005, OK, "R9 ctrl untouched");
    bus_read(12'h014, 32'h0000_00A5, OK, "R9 tps untouched");

    // R10 back-pressure on responses
    bus_write(12'h008, 32'h0102_0304, OK, "R10 slow bready", 3'b000, 4);
    bus_read(12'h008, 32'h0102_0304, OK, "R10 slow rready", 5);
    bus_write(12'h0A0, 32'h5555_AAAA, OK, "R10 R6 table slow", 3'b000, 3);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule